// File: doc/BRIEF.md
# Two-wire packet bus master

This block is the controlling end of a two-wire serial bus with one clock wire and one shared data wire. There is no device-select wire. Every transaction is one fixed 32-bit packet: an 8-bit device address, an 8-bit command, and a 16-bit data word. The address inside the packet is the only way a slave knows it is being spoken to. The master generates the bus clock by dividing the system clock. On writes it shifts the whole packet out.

When the top bit of the command is set, the master turns the data line around after the header. It then collects 16 bits from the slave and presents them on `rdData`.

A host pulses `start` with the address, command and write word present, then waits for `done`. The data wire is modelled as three signals: `sdaOut`, `sdaOe` and `sdaIn`. Outside the block, these resolve to an open line.

Top module: `tw_packet_master`

## Requirements
- R1: A packet is 32 bits sent most significant bit first: address[7:0], then command[7:0], then the data word[15:0]. One bit is presented for each rising edge of `sclk`.
- R2: When command bit 7 is 0 (write), `sdaOe` is 1 for all 32 bit times, and bits 16..31 carry `wrData`.
- R3: When command bit 7 is 1 (read), `sdaOe` is 1 for bits 0..15 and 0 for bits 16..31.
- R4: On a read, the master samples `sdaIn` at each falling edge of bits 16..31, most significant bit first. At the end of the packet, `rdData` holds those 16 bits.
- R5: The master changes `sdaOut` and `sdaOe` only while `sclk` is low. Both are stable across each rising edge and through each high phase.
- R6: Each high and each low half of `sclk` lasts HALF_PERIOD system cycles, so rising edges are 2*HALF_PERIOD cycles apart.
- R7: `done` is 1 for exactly one system cycle after the 32nd falling edge. `busy` is 1 from the cycle after an accepted `start` until the idle gap ends.
- R8: After the last bit, `sclk` is low and `sdaOe` is 0. Both hold for IDLE_HALVES*HALF_PERIOD cycles, counted from the `done` cycle, while `busy` stays 1. `busy` then returns to 0.
- R9: A `start` that arrives while `busy` is 1, either inside a packet or during the idle gap, has no effect on the packet or the gap.
- R10: In reset, `sclk`, `sdaOe`, `busy` and `done` are 0 and `rdData` is 0.
- R11: A write transaction leaves `rdData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to send a packet |
| addr | input | 8 | Device address of the packet |
| cmd | input | 8 | Command byte; bit 7 selects read |
| wrData | input | 16 | Data word sent on a write |
| busy | output | 1 | Packet or idle gap in progress |
| done | output | 1 | One-cycle end-of-packet pulse |
| rdData | output | 16 | Word returned by the last read |
| sclk | output | 1 | Bus clock, idles low |
| sdaOut | output | 1 | Value driven on the data wire |
| sdaOe | output | 1 | Data wire drive enable |
| sdaIn | input | 1 | Resolved level of the data wire |

## Verification
On every cycle, the assertions check three things:
- The data wire holds still across each rising clock edge and high phase.
- `done` is a single-cycle pulse taken with the bus clock low and the line released.
- An accepted start raises `busy`, and `rdData` moves only when a read packet finishes.

Only the bench scenarios can show the rest:
- The bit order of the packet and the turnaround point for read and write commands.
- The exact half-period and idle-gap lengths.
- The word assembled from a slave's reply.
- That a start arriving inside a packet or inside the gap is ignored.

// File: rtl/tw_master_pkg.sv
package tw_master_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_GAP  = 2'd3
  } busState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture packet fields
    logic shift;    // advance transmit register at a falling edge
    logic capture;  // sample sdaIn into receive register
    logic commit;   // last read bit: publish the received word
  } dpStrobe_t;

endpackage

// File: rtl/tw_master_datapath.sv
module tw_master_datapath
  import tw_master_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic [DATA_W-1:0] rdData
);
  localparam int FRAME_W = ADDR_W + CMD_W + DATA_W;

  logic [FRAME_W-1:0] txShift;
  logic [DATA_W-1:0]  rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rdData  <= '0;
    end else begin
      if (strobe.load)
        txShift <= {addr, cmd, wrData};
      else if (strobe.shift)
        txShift <= {txShift[FRAME_W-2:0], 1'b0};
      if (strobe.capture)
        rxShift <= {rxShift[DATA_W-2:0], sdaIn};
      if (strobe.commit)
        rdData <= {rxShift[DATA_W-2:0], sdaIn};
    end
  end

  assign sdaOut = txShift[FRAME_W-1];

  // R11: read word only moves when control commits a read
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(rdData));

endmodule

// File: rtl/tw_master_ctrl.sv
module tw_master_ctrl
  import tw_master_pkg::*;
#(
  parameter int HALF_PERIOD = 4,
  parameter int IDLE_HALVES = 8,
  parameter int FRAME_W     = 32,
  parameter int HDR_W       = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      readReq,
  output logic      sclk,
  output logic      sdaOe,
  output logic      busy,
  output logic      done,
  output dpStrobe_t strobe
);
  localparam int GAP_CYC = IDLE_HALVES * HALF_PERIOD;
  localparam int HC_W    = $clog2(HALF_PERIOD + 1);
  localparam int GC_W    = $clog2(GAP_CYC + 1);
  localparam int BC_W    = $clog2(FRAME_W);

  busState_t       state;
  logic [HC_W-1:0] halfCnt;
  logic [GC_W-1:0] gapCnt;
  logic [BC_W-1:0] bitCnt;
  logic            isRead;
  logic            halfEnd, lastBit, inReply, fallEdge;

  assign halfEnd  = (halfCnt == HC_W'(HALF_PERIOD - 1));
  assign lastBit  = (bitCnt == BC_W'(FRAME_W - 1));
  assign inReply  = isRead && (bitCnt >= BC_W'(HDR_W));
  assign fallEdge = (state == ST_HIGH) && halfEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      gapCnt  <= '0;
      bitCnt  <= '0;
      isRead  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_LOW;
          halfCnt <= '0;
          bitCnt  <= '0;
          isRead  <= readReq;
        end
        ST_LOW: begin
          if (halfEnd) begin
            state   <= ST_HIGH;
            halfCnt <= '0;
          end else begin
            halfCnt <= halfCnt + HC_W'(1);
          end
        end
        ST_HIGH: begin
          if (halfEnd) begin
            halfCnt <= '0;
            if (lastBit) begin
              state  <= ST_GAP;
              gapCnt <= '0;
              done   <= 1'b1;
            end else begin
              bitCnt <= bitCnt + BC_W'(1);
              state  <= ST_LOW;
            end
          end else begin
            halfCnt <= halfCnt + HC_W'(1);
          end
        end
        ST_GAP: begin
          if (gapCnt == GC_W'(GAP_CYC - 1)) state <= ST_IDLE;
          else gapCnt <= gapCnt + GC_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sclk           = (state == ST_HIGH);
    sdaOe          = ((state == ST_LOW) || (state == ST_HIGH)) && !inReply;
    busy           = (state != ST_IDLE);
    strobe.load    = (state == ST_IDLE) && start;
    strobe.shift   = fallEdge;
    strobe.capture = fallEdge && inReply;
    strobe.commit  = fallEdge && inReply && lastBit;
  end

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8: packet ends with clock low and line released
  p_done_released_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!sclk && !sdaOe && busy));
  // R7: an accepted start raises busy on the next cycle
  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

endmodule

// File: rtl/tw_packet_master.sv
module tw_packet_master
  import tw_master_pkg::*;
#(
  parameter int HALF_PERIOD = 4,
  parameter int IDLE_HALVES = 8,
  parameter int ADDR_W      = 8,
  parameter int CMD_W       = 8,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              sclk,
  output logic              sdaOut,
  output logic              sdaOe,
  input  logic              sdaIn
);
  localparam int HDR_W   = ADDR_W + CMD_W;
  localparam int FRAME_W = HDR_W + DATA_W;

  dpStrobe_t strobe;

  tw_master_ctrl #(
    .HALF_PERIOD(HALF_PERIOD),
    .IDLE_HALVES(IDLE_HALVES),
    .FRAME_W    (FRAME_W),
    .HDR_W      (HDR_W)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .readReq(cmd[CMD_W-1]),
    .sclk   (sclk),
    .sdaOe  (sdaOe),
    .busy   (busy),
    .done   (done),
    .strobe (strobe)
  );

  tw_master_datapath #(
    .ADDR_W(ADDR_W),
    .CMD_W (CMD_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .addr  (addr),
    .cmd   (cmd),
    .wrData(wrData),
    .sdaIn (sdaIn),
    .sdaOut(sdaOut),
    .rdData(rdData)
  );

  // R5: data wire settled before the clock rises
  p_rise_setup_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> ($stable(sdaOut) && $stable(sdaOe)));
  // R5: data wire holds through the high phase
  p_high_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> ($stable(sdaOut) && $stable(sdaOe)));

endmodule

// File: tb/test_tw_packet_master.sv
module test_tw_packet_master;
  localparam int HALF = 4;
  localparam int IDLE = 8;
  localparam int NV   = 7;
  // [47:40] addr, [39:32] cmd, [31:16] write word, [15:0] slave reply
  localparam logic [47:0] VECS [0:NV-1] = '{
    48'h5A03_BEEF_0000,
    48'hA581_0000_C3A6,
    48'hFF7F_FFFF_0000,
    48'h0080_1234_8001,
    48'h0100_0000_0000,
    48'h80FF_5555_FFFF,
    48'h3C8F_0000_0000
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [7:0] addr = '0, cmd = '0;
  logic [15:0] wrData = '0;
  logic busy, done, sclk, sdaOut, sdaOe, sdaIn;
  logic [15:0] rdData;
  logic slaveDrive = 1'b0, slaveBit = 1'b0;
  int nChk = 0, nFail = 0, cyc = 0;
  logic [15:0] lastRd = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sdaIn = slaveDrive ? slaveBit : (sdaOe ? sdaOut : 1'b1);

  tw_packet_master #(.HALF_PERIOD(HALF), .IDLE_HALVES(IDLE)) i_tw_packet_master (
    .clk(clk), .rstN(rstN), .start(start), .addr(addr), .cmd(cmd),
    .wrData(wrData), .busy(busy), .done(done), .rdData(rdData),
    .sclk(sclk), .sdaOut(sdaOut), .sdaOe(sdaOe), .sdaIn(sdaIn));

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runTxn(input logic [47:0] v, input bit pokeMid, input bit pokeGap);
    logic [31:0] frame = '0, oeBits = '0, expOe;
    logic isRd = v[39];
    int idx = 0, riseCyc = 0, gapLen, perErr = 0, highErr = 0, guard = 0;
    bit prevSclk = 1'b0, pokeOn = 1'b0, pokeDone = 1'b0, gapErr = 1'b0;
    @(negedge clk);
    addr = v[47:40]; cmd = v[39:32]; wrData = v[31:16]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", busy, 1, "busy after start");
    while (!done && guard < 4000) begin
      guard++;
      if (pokeOn) begin start = 1'b0; pokeOn = 1'b0; end
      if (sclk && !prevSclk) begin
        frame[31-idx]  = sdaOut;
        oeBits[31-idx] = sdaOe;
        if (idx > 0 && (cyc - riseCyc) != 2*HALF) perErr++;
        riseCyc = cyc;
        if (isRd && idx >= 16) begin slaveDrive = 1'b1; slaveBit = v[31-idx]; end
        idx++;
      end
      if (!sclk && prevSclk && (cyc - riseCyc) != HALF) highErr++;
      if (pokeMid && !pokeDone && idx == 5) begin
        addr = 8'hC7; cmd = 8'h00; wrData = 16'h0F0F; start = 1'b1;
        pokeOn = 1'b1; pokeDone = 1'b1;
      end
      prevSclk = sclk;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R1", idx, 32, "rising edges per packet");
    chk("R1", frame[31:16], v[47:32], "header bits");
    if (!isRd) chk("R2", frame[15:0], v[31:16], "write data bits");
    expOe = isRd ? 32'hFFFF_0000 : 32'hFFFF_FFFF;
    chk(isRd ? "R3" : "R2", oeBits, expOe, "drive enable per bit");
    chk("R6", perErr, 0, "bit period errors");
    chk("R6", highErr, 0, "high phase errors");
    chk("R8", {sclk, sdaOe}, 0, "bus at done");
    gapLen = 1;
    slaveDrive = 1'b0;
    @(negedge clk);
    chk("R7", done, 0, "done width");
    while (busy && gapLen < 4000) begin
      gapLen++;
      if (sclk || sdaOe) gapErr = 1'b1;
      if (pokeGap && gapLen == 4) start = 1'b1; else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R8", gapLen, IDLE*HALF, "idle gap length");
    chk("R8", gapErr, 0, "bus active in gap");
    if (pokeGap) chk("R9", {busy, sclk}, 0, "start in gap ignored");
    if (isRd) begin
      lastRd = v[15:0];
      chk("R4", rdData, lastRd, "read word");
    end else begin
      chk("R11", rdData, lastRd, "read word kept on write");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R7 watchdog: actual hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {sclk, sdaOe, busy, done}, 0, "control outputs in reset");
    chk("R10", rdData, 0, "read word in reset");
    start = 1'b1;
    @(negedge clk);
    chk("R10", busy, 0, "start ignored in reset");
    start = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R10", {sclk, sdaOe, busy, done}, 0, "idle after reset");
    for (int i = 0; i < NV; i++) runTxn(VECS[i], 1'b0, 1'b0);
    // R9: start inside a write packet and inside the gap
    runTxn(48'h6602_A5A5_0000, 1'b1, 1'b1);
    // R9 with a read, then R11 after it
    runTxn(48'h9990_0000_7E81, 1'b1, 1'b0);
    runTxn(48'h1111_2222_0000, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule